// File: doc/BRIEF.md
# Double-Buffered CAN Receive Store

This block keeps received CAN frames in two message buffers of 13 bytes each. The bit-level receiver writes frame bytes into a hidden background buffer through a byte-wide write port. The acceptance filter judges the identifier while those bytes arrive. At the end of the frame the receiver pulses a completion strobe together with an error-free indication and the filter verdict. A frame that arrived cleanly and passed the filter is taken as a whole into the foreground buffer. The foreground buffer is the only one the host can read, so every frame appears in the same fixed window of 13 byte addresses.

A receiver-full flag marks the foreground buffer as holding a valid frame. The host reads the frame and then writes one to the flag. That write frees the buffer and drops the interrupt. If the foreground buffer is still occupied when a frame is accepted, the frame waits in the background buffer and moves forward one cycle after the host frees the foreground. A further accepted frame that arrives while one is waiting is lost, and a sticky overrun flag records the loss.

Top module: `can_rx_dual_store`

## Requirements
- R1: Bytes written on the receiver port land only in the background buffer; the host read port shows the foreground buffer, which keeps its contents until a copy happens.
- R2: A completion strobe with the error-free and filter-pass inputs both high, while the full flag is clear and no frame is waiting, moves the whole background frame to the foreground. The full flag reads 1 after the second rising edge counted from the strobe's edge.
- R3: A completion with the filter-pass input low or the error-free input low leaves the foreground contents and the full flag unchanged, and it leaves nothing waiting.
- R4: A host flag write with bit 0 of the write data set clears the full flag. A flag write with bit 0 at zero leaves the full flag as it is.
- R5: The interrupt output equals the full flag ANDed with an enable bit. The enable bit is written through the enable write strobe and resets to 0.
- R6: An accepted frame that completes while the full flag is set waits in the background buffer. It is copied on the first rising edge after the edge that clears the full flag, and the full flag is set again.
- R7: While a frame is waiting, receiver byte writes are ignored. An accepted completion in that state discards the new frame and sets the overrun flag.
- R8: The overrun flag is sticky. Only a host flag write with bit 1 of the write data set clears it.
- R9: A host read address of 13 or above returns 0.
- R10: After reset the full flag, the overrun flag, the interrupt enable and every foreground byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_wr_en | input | 1 | Receiver byte write strobe |
| rx_wr_addr | input | 4 | Byte index within the background buffer |
| rx_wr_data | input | 8 | Received byte |
| rx_done | input | 1 | Frame-complete strobe |
| rx_ok | input | 1 | Frame ended without error (valid with rx_done) |
| rx_pass | input | 1 | Acceptance filter passed (valid with rx_done) |
| host_rd_addr | input | 4 | Host read byte address into the foreground buffer |
| host_rd_data | output | 8 | Foreground byte at host_rd_addr (combinational) |
| host_flag_wr | input | 1 | Host write strobe for the flag register |
| host_flag_wdata | input | 2 | Write-one-to-clear bits: bit 0 full, bit 1 overrun |
| host_ie_wr | input | 1 | Host write strobe for the interrupt enable |
| host_ie_wdata | input | 1 | New interrupt enable value |
| rx_full | output | 1 | Foreground buffer holds an accepted frame |
| rx_ovr | output | 1 | Sticky overrun flag |
| rx_ie | output | 1 | Current interrupt enable |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Each frame carries a distinct byte pattern, so a copy from the wrong frame or a partial copy shows up in the foreground bytes. Frames are sent in four kinds: accepted into an empty foreground, rejected by the filter, ended with an error, and accepted while the foreground is occupied. These kinds separate a correct copy gate from one that ignores the filter verdict, the error indication or the full flag. A third accepted frame during a wait has its own bytes. It shows whether the waiting frame is shielded from overwrite and whether overrun is raised and then held through an unrelated flag write.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
   localparam int CAN_MSG_BYTES = 13;
   localparam int CAN_BYTE_W    = 8;

   // Bit positions of the write-one-to-clear flag register.
   localparam int FLG_FULL_BIT = 0;
   localparam int FLG_OVR_BIT  = 1;
   localparam int FLG_W        = 2;

   typedef struct packed {
      logic ovr_clr;
      logic full_clr;
   } flag_clr_t;
endpackage

// File: rtl/rx_msg_buf.sv
module rx_msg_buf #(
   parameter int DW    = 8,
   parameter int DEPTH = 13,
   parameter int AW    = 4,
   localparam int IMG_W = DW * DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic             ld_en,
   input  logic [IMG_W-1:0] ld_img,
   output logic [IMG_W-1:0] img
);
   // One register per byte; a whole-image load wins over a byte write.
   for (genvar i = 0; i < DEPTH; i++) begin : g_byte
      logic [DW-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (ld_en) begin
            byte_q <= ld_img[i*DW +: DW];
         end else if (wr_en && (wr_addr == AW'(i))) begin
            byte_q <= wr_data;
         end
      end
      assign img[i*DW +: DW] = byte_q;
   end
endmodule

// File: rtl/rx_host_rdport.sv
module rx_host_rdport #(
   parameter int DW    = 8,
   parameter int DEPTH = 13,
   parameter int AW    = 4,
   localparam int IMG_W = DW * DEPTH
) (
   input  logic [IMG_W-1:0] img,
   input  logic [AW-1:0]    addr,
   output logic [DW-1:0]    data
);
   always_comb begin
      data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (addr == AW'(i)) data = img[i*DW +: DW];
      end
   end
endmodule

// File: rtl/rx_store_ctrl.sv
module rx_store_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_done,
   input  logic frame_ok,
   input  logic frame_pass,
   input  logic full_clr,
   input  logic ovr_clr,
   input  logic ie_wr,
   input  logic ie_val,
   output logic full,
   output logic ovr,
   output logic pending,
   output logic copy_en,
   output logic ie,
   output logic irq
);
   logic accept;

   assign accept  = frame_done & frame_ok & frame_pass;
   assign copy_en = pending & ~full;
   assign irq     = full & ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         full    <= 1'b0;
         ovr     <= 1'b0;
         ie      <= 1'b0;
      end else begin
         if (accept && !pending) pending <= 1'b1;
         else if (copy_en)       pending <= 1'b0;

         if (copy_en)       full <= 1'b1;
         else if (full_clr) full <= 1'b0;

         if (accept && pending) ovr <= 1'b1;
         else if (ovr_clr)      ovr <= 1'b0;

         if (ie_wr) ie <= ie_val;
      end
   end
endmodule

// File: rtl/can_rx_dual_store.sv
module can_rx_dual_store #(
   parameter int DW        = can_rx_pkg::CAN_BYTE_W,
   parameter int MSG_BYTES = can_rx_pkg::CAN_MSG_BYTES,
   localparam int AW       = $clog2(MSG_BYTES),
   localparam int IMG_W    = DW * MSG_BYTES
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rx_wr_en,
   input  logic [AW-1:0]                 rx_wr_addr,
   input  logic [DW-1:0]                 rx_wr_data,
   input  logic                          rx_done,
   input  logic                          rx_ok,
   input  logic                          rx_pass,
   input  logic [AW-1:0]                 host_rd_addr,
   output logic [DW-1:0]                 host_rd_data,
   input  logic                          host_flag_wr,
   input  logic [can_rx_pkg::FLG_W-1:0]  host_flag_wdata,
   input  logic                          host_ie_wr,
   input  logic                          host_ie_wdata,
   output logic                          rx_full,
   output logic                          rx_ovr,
   output logic                          rx_ie,
   output logic                          rx_irq
);
   import can_rx_pkg::*;

   if (DW < 1) begin : g_bad_dw
      $error("can_rx_dual_store: DW must be at least 1");
   end
   if (MSG_BYTES < 2) begin : g_bad_depth
      $error("can_rx_dual_store: MSG_BYTES must be at least 2");
   end

   flag_clr_t        clr;
   logic             pend_q;
   logic             copy_en;
   logic             bg_wr_en;
   logic [IMG_W-1:0] bg_img;
   logic [IMG_W-1:0] fg_img;

   assign clr.full_clr = host_flag_wr & host_flag_wdata[FLG_FULL_BIT];
   assign clr.ovr_clr  = host_flag_wr & host_flag_wdata[FLG_OVR_BIT];

   // A waiting frame is protected from the receiver.
   assign bg_wr_en = rx_wr_en & ~pend_q;

   rx_msg_buf #(.DW(DW), .DEPTH(MSG_BYTES), .AW(AW)) u_bg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bg_wr_en),
      .wr_addr (rx_wr_addr),
      .wr_data (rx_wr_data),
      .ld_en   (1'b0),
      .ld_img  ('0),
      .img     (bg_img)
   );

   rx_msg_buf #(.DW(DW), .DEPTH(MSG_BYTES), .AW(AW)) u_fg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (1'b0),
      .wr_addr ('0),
      .wr_data ('0),
      .ld_en   (copy_en),
      .ld_img  (bg_img),
      .img     (fg_img)
   );

   rx_host_rdport #(.DW(DW), .DEPTH(MSG_BYTES), .AW(AW)) u_rd (
      .img  (fg_img),
      .addr (host_rd_addr),
      .data (host_rd_data)
   );

   rx_store_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (rx_done),
      .frame_ok   (rx_ok),
      .frame_pass (rx_pass),
      .full_clr   (clr.full_clr),
      .ovr_clr    (clr.ovr_clr),
      .ie_wr      (host_ie_wr),
      .ie_val     (host_ie_wdata),
      .full       (rx_full),
      .ovr        (rx_ovr),
      .pending    (pend_q),
      .copy_en    (copy_en),
      .ie         (rx_ie),
      .irq        (rx_irq)
   );
endmodule

// File: rtl/can_rx_store_chk.sv
module can_rx_store_chk #(
   parameter int IMG_W = 104
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_done,
   input logic             rx_ok,
   input logic             rx_pass,
   input logic             host_flag_wr,
   input logic [1:0]       host_flag_wdata,
   input logic             pend_q,
   input logic             rx_full,
   input logic             rx_ovr,
   input logic             rx_irq,
   input logic [IMG_W-1:0] fg_img
);
   // R2: a waiting frame with a free foreground fills it on the next edge.
   a_r2_copy_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !rx_full) |=> rx_full);

   // R3: a rejected or faulty frame into an idle store never raises full.
   a_r3_reject_no_full: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_full && !pend_q && rx_done && !(rx_ok && rx_pass)) |=> !rx_full);

   // R4: writing one to the full bit clears it.
   a_r4_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (host_flag_wr && host_flag_wdata[0] && rx_full) |=> !rx_full);

   // R5: interrupt never asserted without a frame present.
   a_r5_irq_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_full);

   // R6: foreground image holds while occupied and not released.
   a_r6_fg_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !(host_flag_wr && host_flag_wdata[0])) |=> $stable(fg_img));

   // R7: overrun rises only when a frame was already waiting.
   a_r7_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr) |-> $past(pend_q));

   // R8: overrun is sticky unless its clear bit is written.
   a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovr && !(host_flag_wr && host_flag_wdata[1])) |=> rx_ovr);
endmodule

bind can_rx_dual_store can_rx_store_chk #(.IMG_W(IMG_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .rx_done         (rx_done),
   .rx_ok           (rx_ok),
   .rx_pass         (rx_pass),
   .host_flag_wr    (host_flag_wr),
   .host_flag_wdata (host_flag_wdata),
   .pend_q          (pend_q),
   .rx_full         (rx_full),
   .rx_ovr          (rx_ovr),
   .rx_irq          (rx_irq),
   .fg_img          (fg_img)
);

// File: tb/can_rx_dual_store_test.sv
`timescale 1ns/1ps
module can_rx_dual_store_test;
   localparam int NB  = 13;
   localparam int AWB = 4;
   localparam int FW  = NB * 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           rx_wr_en = 1'b0;
   logic [AWB-1:0] rx_wr_addr = '0;
   logic [7:0]     rx_wr_data = '0;
   logic           rx_done = 1'b0, rx_ok = 1'b0, rx_pass = 1'b0;
   logic [AWB-1:0] host_rd_addr = '0;
   logic [7:0]     host_rd_data;
   logic           host_flag_wr = 1'b0;
   logic [1:0]     host_flag_wdata = '0;
   logic           host_ie_wr = 1'b0, host_ie_wdata = 1'b0;
   logic           rx_full, rx_ovr, rx_ie, rx_irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [FW-1:0] exp_q[$];

   always #10 clk = ~clk;

   can_rx_dual_store uut (
      .clk(clk), .rst_n(rst_n),
      .rx_wr_en(rx_wr_en), .rx_wr_addr(rx_wr_addr), .rx_wr_data(rx_wr_data),
      .rx_done(rx_done), .rx_ok(rx_ok), .rx_pass(rx_pass),
      .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
      .host_flag_wr(host_flag_wr), .host_flag_wdata(host_flag_wdata),
      .host_ie_wr(host_ie_wr), .host_ie_wdata(host_ie_wdata),
      .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_ie(rx_ie), .rx_irq(rx_irq)
   );

   task automatic check(input bit ok, input string req, input logic [FW-1:0] act,
                        input logic [FW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] mkframe(input int seed);
      logic [FW-1:0] f;
      for (int i = 0; i < NB; i++) f[i*8 +: 8] = 8'((seed * 37) + (i * 29) + 5);
      return f;
   endfunction

   task automatic read_fg(output logic [FW-1:0] f);
      for (int i = 0; i < NB; i++) begin
         host_rd_addr = AWB'(i);
         #0.2;
         f[i*8 +: 8] = host_rd_data;
      end
   endtask

   // Driver: writes a frame then strobes completion; pushes the frame onto
   // the scoreboard when it is expected to reach the foreground.
   task automatic send_frame(input logic [FW-1:0] f, input bit ok, input bit pass,
                             input bit expect_fg);
      for (int i = 0; i < NB; i++) begin
         @(negedge clk);
         rx_wr_en = 1'b1; rx_wr_addr = AWB'(i); rx_wr_data = f[i*8 +: 8];
      end
      @(negedge clk);
      rx_wr_en = 1'b0; rx_done = 1'b1; rx_ok = ok; rx_pass = pass;
      @(negedge clk);
      rx_done = 1'b0; rx_ok = 1'b0; rx_pass = 1'b0;
      if (expect_fg) exp_q.push_back(f);
   endtask

   // Monitor: pops the oldest expected frame and compares the foreground.
   task automatic pop_compare(input string req);
      logic [FW-1:0] got, exp;
      read_fg(got);
      if (exp_q.size() == 0) begin
         check(1'b0, {req, " (scoreboard empty)"}, got, '0);
      end else begin
         exp = exp_q.pop_front();
         check(got === exp, req, got, exp);
      end
   endtask

   task automatic flag_write(input logic [1:0] d);
      @(negedge clk);
      host_flag_wr = 1'b1; host_flag_wdata = d;
      @(negedge clk);
      host_flag_wr = 1'b0; host_flag_wdata = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [FW-1:0] f;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      check(rx_full == 0 && rx_ovr == 0 && rx_ie == 0 && rx_irq == 0, "R10 flags",
            FW'({rx_full, rx_ovr, rx_ie, rx_irq}), '0);
      read_fg(f);
      check(f == '0, "R10 foreground zero", f, '0);

      // R1/R2 accepted frame into idle store
      send_frame(mkframe(1), 1'b1, 1'b1, 1'b1);
      read_fg(f);
      check(f == '0, "R1 foreground untouched before copy", f, '0);
      check(rx_full == 1'b0, "R2 full not yet set", FW'(rx_full), '0);
      @(negedge clk);
      check(rx_full == 1'b1, "R2 full set", FW'(rx_full), FW'(1));
      check(rx_irq == 1'b0, "R5 irq masked", FW'(rx_irq), '0);
      pop_compare("R2 copied frame");

      // R5 enable interrupt
      @(negedge clk);
      host_ie_wr = 1'b1; host_ie_wdata = 1'b1;
      @(negedge clk);
      host_ie_wr = 1'b0;
      check(rx_irq == 1'b1 && rx_ie == 1'b1, "R5 irq with enable",
            FW'({rx_ie, rx_irq}), FW'(3));

      // R4 writing zero has no effect
      flag_write(2'b00);
      check(rx_full == 1'b1, "R4 zero write keeps full", FW'(rx_full), FW'(1));

      // R3 rejected and faulty frames while full
      send_frame(mkframe(2), 1'b1, 1'b0, 1'b0);
      send_frame(mkframe(3), 1'b0, 1'b1, 1'b0);
      repeat (2) @(negedge clk);
      exp_q.push_front(mkframe(1));
      pop_compare("R3 foreground kept after rejects");

      // R4/R5 clear full
      flag_write(2'b01);
      check(rx_full == 1'b0 && rx_irq == 1'b0, "R4 full cleared, R5 irq low",
            FW'({rx_full, rx_irq}), '0);
      repeat (3) @(negedge clk);
      check(rx_full == 1'b0, "R3 nothing pending after rejects", FW'(rx_full), '0);

      // R3 error frame into idle store
      send_frame(mkframe(4), 1'b0, 1'b1, 1'b0);
      repeat (2) @(negedge clk);
      check(rx_full == 1'b0, "R3 error frame not accepted", FW'(rx_full), '0);

      // R6/R7 wait and overrun
      send_frame(mkframe(5), 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      check(rx_full == 1'b1, "R2 second frame full", FW'(rx_full), FW'(1));
      send_frame(mkframe(6), 1'b1, 1'b1, 1'b0);
      repeat (2) @(negedge clk);
      pop_compare("R6 occupied foreground kept");
      exp_q.push_back(mkframe(6));
      check(rx_ovr == 1'b0, "R7 no overrun yet", FW'(rx_ovr), '0);
      send_frame(mkframe(7), 1'b1, 1'b1, 1'b0);
      check(rx_ovr == 1'b1, "R7 overrun set", FW'(rx_ovr), FW'(1));
      @(negedge clk);
      host_flag_wr = 1'b1; host_flag_wdata = 2'b01;
      @(negedge clk);
      host_flag_wr = 1'b0; host_flag_wdata = '0;
      check(rx_full == 1'b0, "R6 full cleared by host", FW'(rx_full), '0);
      @(negedge clk);
      check(rx_full == 1'b1, "R6 waiting frame copied next edge", FW'(rx_full), FW'(1));
      pop_compare("R7 waiting frame intact");

      // R8 sticky overrun
      check(rx_ovr == 1'b1, "R8 overrun survives full clear", FW'(rx_ovr), FW'(1));
      flag_write(2'b00);
      check(rx_ovr == 1'b1, "R8 zero write keeps overrun", FW'(rx_ovr), FW'(1));
      flag_write(2'b10);
      check(rx_ovr == 1'b0, "R8 overrun cleared", FW'(rx_ovr), '0);
      check(rx_full == 1'b1, "R4 ovr clear keeps full", FW'(rx_full), FW'(1));

      // R9 out-of-range read
      host_rd_addr = 4'd13; #0.2;
      check(host_rd_data == 8'h00, "R9 addr 13", FW'(host_rd_data), '0);
      host_rd_addr = 4'd15; #0.2;
      check(host_rd_data == 8'h00, "R9 addr 15", FW'(host_rd_data), '0);

      // R2 normal flow resumes
      flag_write(2'b01);
      send_frame(mkframe(8), 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      check(rx_full == 1'b1 && rx_irq == 1'b1, "R2 resumed, R5 irq",
            FW'({rx_full, rx_irq}), FW'(3));
      pop_compare("R2 resumed frame");
      check(exp_q.size() == 0, "R2 scoreboard drained", FW'(exp_q.size()), '0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule